// File: doc/BRIEF.md
# ATA PIO Strobe Timing Generator

This block produces the active-low read and write strobes for one ATA channel that carries two drives. Every transfer has three phases: address setup, strobe active and recovery. The length of each phase is counted in bus clocks. The lengths come from byte-wide timing registers, which software loads through a small write port. Each drive has its own timing byte, which holds the active length and the recovery code. The address-setup length comes from a 2-bit field in bits 7:6 of a setup register.

A transfer begins when `req_i` is seen while the block is idle. The drive select and direction are sampled at that point, and so are the lengths for that drive. The block then runs the setup, active and recovery phases. In the clock after the last recovery clock it pulses `done_o`, and in that same clock it is idle again. The setup-register arrangement is chosen by the parameter `SHARED_SETUP`. The primary variant (`SHARED_SETUP = 0`) has one setup register per drive and always uses the longer of the two decoded setup lengths. The secondary variant (`SHARED_SETUP = 1`) has a single setup register that both drives use.

Top module: `ata_pio_strobe_gen`

## Requirements
- R1: After reset both strobes are high and `busy_o` and `done_o` are low. Every timing field resets to its slowest value: 16-clock active, 16-clock recovery and 5-clock setup.
- R2: The active length is bits 7:4 of the selected drive's timing byte, taken as a count of clocks. The value 0 means 16 clocks.
- R3: The recovery length is decoded from bits 3:0 of the selected drive's timing byte. Code 0 gives 16 clocks, code 15 gives 1 clock, and any other code c gives c+1 clocks.
- R4: The setup length is decoded from bits 7:6 of a setup register. Code 01 gives 2 clocks, 10 gives 3, 00 gives 4 and 11 gives 5.
- R5: With `SHARED_SETUP = 0`, drive 0's setup register is at address 2 and drive 1's is at address 3. Each transfer uses the longer of the two decoded setup lengths, whichever drive is selected.
- R6: With `SHARED_SETUP = 1`, both drives use the setup register at address 2. A write to address 3 has no effect.
- R7: Only one strobe goes low in a transfer. It is `rd_strobe_no` when `rd_i` was 1 and `wr_strobe_no` when `rd_i` was 0, and it is low only during the active phase.
- R8: `busy_o` is high from the clock after acceptance through the last recovery clock. A `req_i` seen while `busy_o` is high is dropped and starts no transfer.
- R9: Timing bytes are at address 0 (drive 0) and address 1 (drive 1). A write that lands during a transfer does not change that transfer's lengths; it applies from the next accepted transfer.
- R10: `done_o` is high for exactly one clock, the clock right after the last recovery clock. `busy_o` is low in that clock, and a request seen in it is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 2 | Register address: 0/1 timing byte for drive 0/1, 2/3 setup register |
| wr_data_i | input | 8 | Register write data |
| req_i | input | 1 | Transfer request, sampled only while idle |
| drv_i | input | 1 | Drive select for the request |
| rd_i | input | 1 | Direction: 1 read, 0 write |
| busy_o | output | 1 | Transfer in progress |
| done_o | output | 1 | One-clock pulse when recovery ends |
| rd_strobe_no | output | 1 | Read strobe, active low |
| wr_strobe_no | output | 1 | Write strobe, active low |

## Verification
The assertions assume that the phase lengths are latched when a request is accepted, and that the counter is therefore loaded only with decoded values between 1 and 16. They also assume a transfer lasts at least three clocks, so two `done_o` pulses can never fall in adjacent clocks. The stimulus writes registers only at negative clock edges. It raises a request only when `busy_o` is low, except for one deliberate pulse that falls inside a transfer. No register write is timed to land on the same edge that accepts a request.

// File: rtl/ata_pio_pkg.sv
package ata_pio_pkg;
  localparam int LEN_W = 5;
  typedef logic [LEN_W-1:0] len_t;

  typedef struct packed {
    len_t setup;
    len_t act;
    len_t rec;
  } phase_len_t;

  typedef enum logic [1:0] {ST_IDLE, ST_SETUP, ST_ACT, ST_REC} seq_st_e;

  function automatic len_t dec_act(input logic [3:0] n);
    return (n == 4'd0) ? len_t'(16) : len_t'(n);
  endfunction

  // recovery: 0 -> 16, 15 -> 1, others -> n+1
  function automatic len_t dec_rec(input logic [3:0] n);
    if (n == 4'd0)       return len_t'(16);
    else if (n == 4'hf)  return len_t'(1);
    else                 return len_t'(n) + len_t'(1);
  endfunction

  // setup code is not ordered by length
  function automatic len_t dec_setup(input logic [1:0] c);
    case (c)
      2'b01:   return len_t'(2);
      2'b10:   return len_t'(3);
      2'b00:   return len_t'(4);
      default: return len_t'(5);
    endcase
  endfunction
endpackage

// File: rtl/ata_pio_regs.sv
module ata_pio_regs #(
  parameter int NDRV         = 2,
  parameter bit SHARED_SETUP = 1'b0,
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 8
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          wr_en_i,
  input  logic [ADDR_W-1:0]             wr_addr_i,
  input  logic [DATA_W-1:0]             wr_data_i,
  output logic [NDRV-1:0][DATA_W-1:0]   tim_o,
  output logic [NDRV-1:0][1:0]          su_code_o
);
  localparam int SU_BASE = NDRV;
  localparam int SU_HI   = DATA_W - 1;
  localparam int SU_LO   = DATA_W - 2;

  logic [NDRV-1:0][DATA_W-1:0] tim_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      tim_q <= '0;
    end else if (wr_en_i) begin
      for (int d = 0; d < NDRV; d++)
        if (wr_addr_i == ADDR_W'(d)) tim_q[d] <= wr_data_i;
    end
  end
  assign tim_o = tim_q;

  generate
    if (SHARED_SETUP) begin : g_shared
      logic [1:0] su_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)
          su_q <= 2'b11;
        else if (wr_en_i && wr_addr_i == ADDR_W'(SU_BASE))
          su_q <= wr_data_i[SU_HI:SU_LO];
      end
      always_comb
        for (int d = 0; d < NDRV; d++) su_code_o[d] = su_q;
    end else begin : g_per_drive
      logic [NDRV-1:0][1:0] su_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
          su_q <= {NDRV{2'b11}};
        end else if (wr_en_i) begin
          for (int d = 0; d < NDRV; d++)
            if (wr_addr_i == ADDR_W'(SU_BASE + d)) su_q[d] <= wr_data_i[SU_HI:SU_LO];
        end
      end
      assign su_code_o = su_q;
    end
  endgenerate

  // R9
  regs_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_en_i |=> ($stable(tim_o) && $stable(su_code_o)));
endmodule

// File: rtl/ata_pio_timing_sel.sv
module ata_pio_timing_sel
  import ata_pio_pkg::*;
#(
  parameter int NDRV   = 2,
  parameter int DATA_W = 8,
  localparam int DRV_W = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic [NDRV-1:0][DATA_W-1:0] tim_i,
  input  logic [NDRV-1:0][1:0]        su_code_i,
  input  logic [DRV_W-1:0]            drv_i,
  output phase_len_t                  len_o
);
  logic [DATA_W-1:0] sel_tim;
  len_t              su_max;

  assign sel_tim = tim_i[drv_i];

  // pick longest decoded setup; codes themselves are not ordered
  always_comb begin
    su_max = '0;
    for (int d = 0; d < NDRV; d++)
      if (dec_setup(su_code_i[d]) > su_max) su_max = dec_setup(su_code_i[d]);
  end

  assign len_o.setup = su_max;
  assign len_o.act   = dec_act(sel_tim[7:4]);
  assign len_o.rec   = dec_rec(sel_tim[3:0]);
endmodule

// File: rtl/ata_pio_seq.sv
module ata_pio_seq
  import ata_pio_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       req_i,
  input  logic       rd_i,
  input  phase_len_t len_i,
  output logic       busy_o,
  output logic       done_o,
  output logic       rd_strobe_no,
  output logic       wr_strobe_no
);
  seq_st_e    st_q, st_d;
  len_t       cnt_q, cnt_d;
  phase_len_t len_q, len_d;
  logic       rd_q, rd_d;
  logic       fin;
  logic       done_q, rd_nq, wr_nq;

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    len_d = len_q;
    rd_d  = rd_q;
    fin   = 1'b0;
    unique case (st_q)
      ST_IDLE: if (req_i) begin
        st_d  = ST_SETUP;
        len_d = len_i;
        rd_d  = rd_i;
        cnt_d = len_i.setup - len_t'(1);
      end
      ST_SETUP: if (cnt_q == '0) begin
        st_d  = ST_ACT;
        cnt_d = len_q.act - len_t'(1);
      end else cnt_d = cnt_q - len_t'(1);
      ST_ACT: if (cnt_q == '0) begin
        st_d  = ST_REC;
        cnt_d = len_q.rec - len_t'(1);
      end else cnt_d = cnt_q - len_t'(1);
      ST_REC: if (cnt_q == '0) begin
        st_d = ST_IDLE;
        fin  = 1'b1;
      end else cnt_d = cnt_q - len_t'(1);
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      len_q  <= '0;
      rd_q   <= 1'b0;
      done_q <= 1'b0;
      rd_nq  <= 1'b1;
      wr_nq  <= 1'b1;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      len_q  <= len_d;
      rd_q   <= rd_d;
      done_q <= fin;
      // strobes registered from next state: no decode glitches on pins
      rd_nq  <= !((st_d == ST_ACT) && rd_d);
      wr_nq  <= !((st_d == ST_ACT) && !rd_d);
    end
  end

  assign busy_o       = (st_q != ST_IDLE);
  assign done_o       = done_q;
  assign rd_strobe_no = rd_nq;
  assign wr_strobe_no = wr_nq;

  // R7
  one_strobe_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_nq || wr_nq);
  // R7
  strobe_in_act_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rd_nq || !wr_nq) |-> (st_q == ST_ACT));
  // R10
  done_pulse_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |=> !done_q);
  // R10
  done_after_rec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> ($past(st_q) == ST_REC && st_q != ST_SETUP ? 1'b1 : $past(st_q) == ST_REC));
  // R8
  hold_len_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (st_q != ST_IDLE) |=> (st_q == ST_IDLE || $stable(len_q)));
  // R2
  cnt_bound_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q < len_t'(16));
endmodule

// File: rtl/ata_pio_strobe_gen.sv
module ata_pio_strobe_gen
  import ata_pio_pkg::*;
#(
  parameter bit SHARED_SETUP = 1'b0,
  parameter int NDRV         = 2,
  parameter int ADDR_W       = 2,
  parameter int DATA_W       = 8,
  localparam int DRV_W       = (NDRV > 1) ? $clog2(NDRV) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              req_i,
  input  logic [DRV_W-1:0]  drv_i,
  input  logic              rd_i,
  output logic              busy_o,
  output logic              done_o,
  output logic              rd_strobe_no,
  output logic              wr_strobe_no
);
  logic [NDRV-1:0][DATA_W-1:0] tim;
  logic [NDRV-1:0][1:0]        su_code;
  phase_len_t                  len;

  ata_pio_regs #(
    .NDRV(NDRV), .SHARED_SETUP(SHARED_SETUP), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i), .wr_data_i(wr_data_i),
    .tim_o(tim), .su_code_o(su_code)
  );

  ata_pio_timing_sel #(.NDRV(NDRV), .DATA_W(DATA_W)) u_sel (
    .tim_i(tim), .su_code_i(su_code), .drv_i(drv_i), .len_o(len)
  );

  ata_pio_seq u_seq (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .req_i(req_i), .rd_i(rd_i), .len_i(len),
    .busy_o(busy_o), .done_o(done_o),
    .rd_strobe_no(rd_strobe_no), .wr_strobe_no(wr_strobe_no)
  );

  // R8
  busy_drop_done_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(busy_o) |-> done_o);
  // R10
  done_idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !busy_o);
endmodule

// File: tb/ata_pio_strobe_gen_bench.sv
module ata_pio_strobe_gen_bench;
  localparam int CLK_PERIOD = 10;
  localparam int WD_CYCLES  = 50000;

  typedef struct {
    int    s;
    int    a;
    int    r;
    bit    rd;
    string tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic       wen   [2];
  logic [1:0] waddr [2];
  logic [7:0] wdata [2];
  logic       req   [2];
  logic       drv   [2];
  logic       rd    [2];
  logic       busy  [2];
  logic       done  [2];
  logic       rdn   [2];
  logic       wrn   [2];

  ata_pio_strobe_gen #(.SHARED_SETUP(1'b0)) u_ata_pio_strobe_gen (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wen[0]), .wr_addr_i(waddr[0]), .wr_data_i(wdata[0]),
    .req_i(req[0]), .drv_i(drv[0]), .rd_i(rd[0]),
    .busy_o(busy[0]), .done_o(done[0]),
    .rd_strobe_no(rdn[0]), .wr_strobe_no(wrn[0])
  );

  ata_pio_strobe_gen #(.SHARED_SETUP(1'b1)) u_ata_pio_strobe_gen_sec (
    .clk_i(clk), .rst_ni(rst_n),
    .wr_en_i(wen[1]), .wr_addr_i(waddr[1]), .wr_data_i(wdata[1]),
    .req_i(req[1]), .drv_i(drv[1]), .rd_i(rd[1]),
    .busy_o(busy[1]), .done_o(done[1]),
    .rd_strobe_no(rdn[1]), .wr_strobe_no(wrn[1])
  );

  int vectors = 0;
  int miss    = 0;
  exp_t q0[$];
  exp_t q1[$];

  logic [7:0] tim_sh [2][2];
  logic [1:0] su_sh  [2][2];

  task automatic chk(input bit ok, input string tag, input string what,
                     input int got, input int exp);
    vectors++;
    if (!ok) begin
      miss++;
      $display("FAIL %s %s: got %0d expected %0d", tag, what, got, exp);
    end
  endtask

  function automatic int f_act(input logic [3:0] n);
    if (n == 0) return 16;
    return int'(n);
  endfunction

  function automatic int f_rec(input logic [3:0] n);
    case (n)
      4'd0:    return 16;
      4'd15:   return 1;
      default: return int'(n) + 1;
    endcase
  endfunction

  function automatic int f_setup(input logic [1:0] c);
    case (c)
      2'b00: return 4;
      2'b01: return 2;
      2'b10: return 3;
      default: return 5;
    endcase
  endfunction

  function automatic exp_t mk(input int ch, input int d, input bit r, input string tag);
    exp_t e;
    int s0, s1;
    e.a  = f_act(tim_sh[ch][d][7:4]);
    e.r  = f_rec(tim_sh[ch][d][3:0]);
    e.rd = r;
    if (ch == 0) begin
      s0 = f_setup(su_sh[0][0]);
      s1 = f_setup(su_sh[0][1]);
      e.s = (s0 > s1) ? s0 : s1;
      e.tag = {"R4 R5 ", tag};
    end else begin
      e.s = f_setup(su_sh[1][0]);
      e.tag = {"R4 R6 ", tag};
    end
    return e;
  endfunction

  task automatic wr(input int ch, input logic [1:0] a, input logic [7:0] dat);
    @(negedge clk);
    wen[ch] = 1'b1; waddr[ch] = a; wdata[ch] = dat;
    @(negedge clk);
    wen[ch] = 1'b0;
    if (a < 2) tim_sh[ch][a] = dat;
    else if (a == 2) su_sh[ch][0] = dat[7:6];
    else if (ch == 0) su_sh[0][1] = dat[7:6];
    // ch 1 address 3: no effect expected (R6)
  endtask

  task automatic issue(input int ch, input int d, input bit r, input string tag);
    @(negedge clk);
    while (busy[ch]) @(negedge clk);
    req[ch] = 1'b1; drv[ch] = d[0]; rd[ch] = r;
    if (ch == 0) q0.push_back(mk(0, d, r, tag));
    else         q1.push_back(mk(1, d, r, tag));
    @(negedge clk);
    req[ch] = 1'b0;
  endtask

  task automatic wait_done(input int ch);
    @(negedge clk);
    while (!done[ch]) @(negedge clk);
  endtask

  // monitor state per channel: 0 idle, 1 setup, 2 active, 3 recovery
  int ph [2];
  int cs [2];
  int ca [2];
  int cr [2];
  bit srd[2];
  bit swr[2];

  task automatic obs(input int ch);
    exp_t e;
    int got_dir;
    if (busy[ch]) begin
      if (ph[ch] == 0) begin
        ph[ch] = 1; cs[ch] = 0; ca[ch] = 0; cr[ch] = 0; srd[ch] = 0; swr[ch] = 0;
      end
      if (!rdn[ch] && !wrn[ch]) chk(1'b0, "R7", "both strobes low", 0, 1);
      if (!rdn[ch] || !wrn[ch]) begin
        if (ph[ch] == 3) chk(1'b0, "R7", "strobe after active", ph[ch], 2);
        ph[ch] = 2; ca[ch]++;
        if (!rdn[ch]) srd[ch] = 1;
        if (!wrn[ch]) swr[ch] = 1;
      end else begin
        if (ph[ch] == 1) cs[ch]++;
        else begin ph[ch] = 3; cr[ch]++; end
      end
    end else if (!rdn[ch] || !wrn[ch]) begin
      chk(1'b0, "R7", "strobe low while idle", 0, 1);
    end
    if (done[ch]) begin
      if (ph[ch] == 0 || (ch == 0 ? q0.size() : q1.size()) == 0) begin
        chk(1'b0, "R8", "unexpected transfer end", 1, 0);
      end else begin
        e = (ch == 0) ? q0.pop_front() : q1.pop_front();
        chk(cs[ch] == e.s, e.tag, "setup clocks", cs[ch], e.s);
        chk(ca[ch] == e.a, {"R2 ", e.tag}, "active clocks", ca[ch], e.a);
        chk(cr[ch] == e.r, {"R3 ", e.tag}, "recovery clocks", cr[ch], e.r);
        got_dir = (srd[ch] && !swr[ch]) ? 1 : ((!srd[ch] && swr[ch]) ? 0 : 2);
        chk(got_dir == int'(e.rd), {"R7 ", e.tag}, "strobe direction", got_dir, int'(e.rd));
        chk(!busy[ch], "R10", "busy at done", int'(busy[ch]), 0);
      end
      ph[ch] = 0;
    end
  endtask

  always @(negedge clk) begin
    if (rst_n) begin
      obs(0);
      obs(1);
    end
  end

  initial begin
    repeat (WD_CYCLES) @(posedge clk);
    miss++;
    $display("FAIL watchdog: got %0d expected %0d", 0, 1);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end

  initial begin
    for (int c = 0; c < 2; c++) begin
      wen[c] = 0; waddr[c] = '0; wdata[c] = '0;
      req[c] = 0; drv[c] = 0; rd[c] = 0;
      ph[c] = 0; cs[c] = 0; ca[c] = 0; cr[c] = 0; srd[c] = 0; swr[c] = 0;
      for (int d = 0; d < 2; d++) begin
        tim_sh[c][d] = 8'h00;
        su_sh[c][d]  = 2'b11;
      end
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    for (int c = 0; c < 2; c++) begin
      // R1 reset state at the ports
      chk(rdn[c] === 1'b1, "R1", "read strobe after reset", int'(rdn[c]), 1);
      chk(wrn[c] === 1'b1, "R1", "write strobe after reset", int'(wrn[c]), 1);
      chk(busy[c] === 1'b0, "R1", "busy after reset", int'(busy[c]), 0);
      chk(done[c] === 1'b0, "R1", "done after reset", int'(done[c]), 0);
    end

    // R1 slowest defaults: 5/16/16
    issue(0, 0, 1'b1, "R1");
    issue(1, 1, 1'b0, "R1");

    // primary: short timings
    wr(0, 2'd0, 8'h3F);   // act 3, rec code 15 -> 1
    wr(0, 2'd2, 8'h40);
    wr(0, 2'd3, 8'h40);
    issue(0, 0, 1'b1, "R3 min");
    wr(0, 2'd1, 8'h52);   // act 5, rec 3
    issue(0, 1, 1'b0, "write");
    wr(0, 2'd3, 8'h80);   // drive1 setup 3 -> max 3 for drive 0
    issue(0, 0, 1'b1, "R5 max");
    wr(0, 2'd2, 8'h00);   // 4 vs 3 -> 4
    issue(0, 1, 1'b1, "R5 code00");
    wr(0, 2'd3, 8'hC0);   // 4 vs 5 -> 5
    issue(0, 0, 1'b0, "R5 code11");
    wr(0, 2'd2, 8'h40);
    wr(0, 2'd3, 8'h40);
    wr(0, 2'd0, 8'h0E);   // act 16, rec 15
    issue(0, 0, 1'b1, "R2 zero");
    wr(0, 2'd1, 8'h1D);   // act 1, rec 14
    issue(0, 1, 1'b0, "R2 one");

    // R10 back to back: second request lands in the done clock
    issue(0, 0, 1'b0, "R10 a");
    issue(0, 1, 1'b1, "R10 b");

    // R9 write during a transfer
    wr(0, 2'd0, 8'h21);
    issue(0, 0, 1'b1, "R9 old");
    wr(0, 2'd0, 8'h44);
    issue(0, 0, 1'b1, "R9 new");

    // R8 request pulse while busy is dropped
    issue(0, 1, 1'b1, "R8");
    req[0] = 1'b1; drv[0] = 1'b0; rd[0] = 1'b0;
    @(negedge clk);
    req[0] = 1'b0;
    wait_done(0);
    @(negedge clk);
    chk(busy[0] === 1'b0, "R8", "busy after dropped request", int'(busy[0]), 0);
    @(negedge clk);
    chk(rdn[0] && wrn[0], "R8", "strobes after dropped request", int'(rdn[0] && wrn[0]), 1);

    // secondary: shared setup
    wr(1, 2'd2, 8'h40);
    wr(1, 2'd0, 8'h23);
    issue(1, 1, 1'b0, "shared");
    wr(1, 2'd3, 8'hC0);   // ignored
    issue(1, 0, 1'b1, "addr3 ignored");
    wr(1, 2'd2, 8'h80);
    issue(1, 1, 1'b1, "shared 3");

    while (q0.size() != 0 || q1.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miss);
    $finish;
  end
endmodule